// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models a serial EEPROM device for use inside a larger chip or a board-level simulation. A host selects it with a chip-select line and clocks in commands on a data-in line against a shift clock. Data leaves on a data-out line that has its own output enable. A strap input picks the word size: 8-bit or 16-bit. The storage is a register file of `ARRAY_BYTES` bytes. A fast system clock oversamples chip select, shift clock and data in, so all of the block's state sits in one clock domain.

Each command opens with a one bit, then a 2-bit opcode, then an address. Four opcodes exist: read, write, erase, and a special group whose function is chosen by the two top address bits. The special group enables or disables programming, erases the whole array, or writes the whole array. A read begins with a zero bit and then streams words for as long as chip select stays high. A programming command starts a busy interval whose length is `PROG_CYCLES` system clocks. The host can poll for the end of that interval on data out by taking chip select low and then high again.

Top module: `sereep_slave`

## Requirements
- R1: After reset, every byte of the array reads as 0xFF and programming is disabled.
- R2: While chip select is high and no command is open, zero bits on data in are ignored. A command begins at the first one bit sampled on a rising shift-clock edge.
- R3: The two bits after the start bit are the opcode, most significant first: 10 reads, 01 writes one word, 11 erases one word, 00 selects the special group.
- R4: In the special group, the two most significant address bits select the function: 11 enables programming, 00 disables it, 10 sets every array bit to one, 01 writes the following data word into every word. The remaining address bits are clocked in and ignored.
- R5: With org16 low, words are 8 bits and the address has log2(ARRAY_BYTES) bits. With org16 high, words are 16 bits, the address has one bit fewer, and 16-bit word k is byte 2k (upper half) joined to byte 2k+1 (lower half).
- R6: After the last address bit of a read, data out is enabled and carries one zero bit. The addressed word follows, most significant bit first. Data out changes only after a rising shift-clock edge.
- R7: While chip select stays high, a read continues with the next word and no zero bit between words. The pointer wraps from the top word to word 0.
- R8: Write, erase, erase-all and write-all change nothing while programming is disabled, and they start no busy interval. Reads work whether programming is enabled or disabled.
- R9: Erase sets every bit of the addressed word to one. Write stores the received word over any old contents, with no erase needed first.
- R10: After a programming command starts, chip select may go low for at least MIN_CS_LOW system clocks and then high. If it does, data out is enabled and shows 0 while busy and 1 once done, until chip select falls. A shorter low, or a rise after the interval has ended, leaves data out disabled.
- R11: The busy interval lasts exactly PROG_CYCLES system clocks and starts after the last data bit (or the last address bit, for erase and erase-all). Commands that begin while busy are ignored.
- R12: Data out is disabled while chip select is low. A fall of chip select discards a partly received command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial shift clock |
| di | input | 1 | Serial data in |
| org16 | input | 1 | Word-size strap: 1 for 16-bit words, 0 for 8-bit words |
| dout | output | 1 | Serial data out |
| dout_oe | output | 1 | Output enable for dout |

## Verification
The hardest situation to reach is a command that arrives during the busy interval without the status display masking it. Any ordinary chip-select low-then-high during that interval turns on ready/busy mode, and that mode ignores the shift clock on its own. The stimulus therefore drops chip select for only two system clocks, which is too short to arm the status display. It then clocks in a complete write to a second address while the first write is still busy. The bench checks that data out stays disabled, that a later proper poll still sees busy, and that the second address keeps its old value.

// File: rtl/sereep_pkg.sv
package sereep_pkg;

   typedef enum logic [1:0] {
      OP_SPECIAL = 2'b00,
      OP_WRITE   = 2'b01,
      OP_READ    = 2'b10,
      OP_ERASE   = 2'b11
   } op_e;

   typedef enum logic [1:0] {
      SUB_LOCK     = 2'b00,
      SUB_FILL     = 2'b01,
      SUB_CLEARALL = 2'b10,
      SUB_UNLOCK   = 2'b11
   } sub_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD,
      ST_DATA,
      ST_READ,
      ST_HOLD
   } st_e;

   typedef enum logic {
      PK_WORD,
      PK_FILL
   } pk_e;

endpackage

// File: rtl/sereep_insync.sv
module sereep_insync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic cs,
   input  logic sk,
   input  logic di,
   output logic cs_s,
   output logic cs_rise,
   output logic sk_rise,
   output logic di_s
);
   logic [STAGES-1:0] cs_p, sk_p, di_p;
   logic              cs_prev, sk_prev;

   always_ff @(posedge clk) begin
      if (rst) begin
         cs_p    <= '0;
         sk_p    <= '0;
         di_p    <= '0;
         cs_prev <= 1'b0;
         sk_prev <= 1'b0;
      end else begin
         cs_p    <= {cs_p[STAGES-2:0], cs};
         sk_p    <= {sk_p[STAGES-2:0], sk};
         di_p    <= {di_p[STAGES-2:0], di};
         cs_prev <= cs_p[STAGES-1];
         sk_prev <= sk_p[STAGES-1];
      end
   end

   assign cs_s    = cs_p[STAGES-1];
   assign di_s    = di_p[STAGES-1];
   assign cs_rise = cs_p[STAGES-1] & ~cs_prev;
   assign sk_rise = sk_p[STAGES-1] & ~sk_prev;
endmodule

// File: rtl/sereep_store.sv
module sereep_store #(
   parameter int NB = 512,
   parameter int BA = 9
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          is16,
   input  logic          we,
   input  logic          fill,
   input  logic [BA-1:0] waddr,
   input  logic [15:0]   wdata,
   input  logic [BA-1:0] raddr,
   output logic [15:0]   rdata
);
   logic [NB*8-1:0] flat;
   logic [BA-1:0]   ra_even, ra_odd;

   for (genvar i = 0; i < NB; i++) begin : g_cell
      logic [7:0] q;
      logic [7:0] lane;
      logic       hit;
      assign lane = (is16 && (i % 2 == 0)) ? wdata[15:8] : wdata[7:0];
      assign hit  = is16 ? (waddr[BA-2:0] == (BA-1)'(i / 2)) : (waddr == BA'(i));
      always_ff @(posedge clk) begin
         if (rst)
            q <= 8'hFF;
         else if (fill || (we && hit))
            q <= lane;
      end
      assign flat[i*8 +: 8] = q;
   end

   assign ra_even = {raddr[BA-2:0], 1'b0};
   assign ra_odd  = {raddr[BA-2:0], 1'b1};

   always_comb begin
      if (is16)
         rdata = {flat[8*int'(ra_even) +: 8], flat[8*int'(ra_odd) +: 8]};
      else
         rdata = {8'h00, flat[8*int'(raddr) +: 8]};
   end
endmodule

// File: rtl/sereep_ptimer.sv
module sereep_ptimer #(
   parameter int CYCLES = 2000
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic busy
);
   localparam int CW = $clog2(CYCLES + 1);
   logic [CW-1:0] left;

   always_ff @(posedge clk) begin
      if (rst)
         left <= '0;
      else if (start)
         left <= CW'(CYCLES);
      else if (left != '0)
         left <= left - 1'b1;
   end

   assign busy = (left != '0);
endmodule

// File: rtl/sereep_slave.sv
module sereep_slave
   import sereep_pkg::*;
#(
   parameter int ARRAY_BYTES = 512,
   parameter int PROG_CYCLES = 2000,
   parameter int MIN_CS_LOW  = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic cs,
   input  logic sk,
   input  logic di,
   input  logic org16,
   output logic dout,
   output logic dout_oe
);
   localparam int BA  = $clog2(ARRAY_BYTES);
   localparam int SRW = BA + 2;
   localparam int LCW = $clog2(MIN_CS_LOW + 1);

   initial begin
      assert (ARRAY_BYTES == (1 << BA) && BA >= 4 && BA <= 13)
         else $error("ARRAY_BYTES must be a power of two from 16 to 8192");
      assert (PROG_CYCLES >= 1) else $error("PROG_CYCLES must be at least 1");
      assert (MIN_CS_LOW >= 1) else $error("MIN_CS_LOW must be at least 1");
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
   end

   logic cs_s, cs_rise, sk_rise, di_s;
   logic busy, busy_q;

   st_e            st;
   pk_e            pend;
   logic [SRW-1:0] cmd_sr, nsr;
   logic [4:0]     cnt, need;
   logic [15:0]    dsr, ndsr, rword;
   logic [BA-1:0]  ptr, ptr_inc, addr, waddr_q;
   logic [15:0]    wdata_q;
   logic [3:0]     bidx, wlast;
   logic [LCW-1:0] low_cnt;
   logic           we_q, fill_q, start_q, prog_en;
   logic           rd_on, dreg, stat_mode, armed, rbit;
   op_e            op;
   sub_e           sub;

   sereep_insync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .cs      (cs),
      .sk      (sk),
      .di      (di),
      .cs_s    (cs_s),
      .cs_rise (cs_rise),
      .sk_rise (sk_rise),
      .di_s    (di_s)
   );

   sereep_store #(.NB(ARRAY_BYTES), .BA(BA)) u_store (
      .clk   (clk),
      .rst   (rst),
      .is16  (org16),
      .we    (we_q),
      .fill  (fill_q),
      .waddr (waddr_q),
      .wdata (wdata_q),
      .raddr (ptr),
      .rdata (rword)
   );

   sereep_ptimer #(.CYCLES(PROG_CYCLES)) u_timer (
      .clk   (clk),
      .rst   (rst),
      .start (start_q),
      .busy  (busy)
   );

   always_comb begin
      nsr     = {cmd_sr[SRW-2:0], di_s};
      op      = op_e'(org16 ? nsr[BA:BA-1] : nsr[BA+1:BA]);
      sub     = sub_e'(org16 ? nsr[BA-2:BA-3] : nsr[BA-1:BA-2]);
      addr    = org16 ? {1'b0, nsr[BA-2:0]} : nsr[BA-1:0];
      need    = org16 ? 5'(BA + 1) : 5'(BA + 2);
      wlast   = org16 ? 4'd15 : 4'd7;
      ndsr    = {dsr[14:0], di_s};
      ptr_inc = org16 ? {1'b0, ptr[BA-2:0] + 1'b1} : ptr + 1'b1;
      rbit    = rword[wlast - bidx];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st        <= ST_IDLE;
         pend      <= PK_WORD;
         cmd_sr    <= '0;
         cnt       <= '0;
         dsr       <= '0;
         ptr       <= '0;
         waddr_q   <= '0;
         wdata_q   <= '0;
         bidx      <= '0;
         low_cnt   <= '0;
         we_q      <= 1'b0;
         fill_q    <= 1'b0;
         start_q   <= 1'b0;
         prog_en   <= 1'b0;
         rd_on     <= 1'b0;
         dreg      <= 1'b0;
         stat_mode <= 1'b0;
         armed     <= 1'b0;
         busy_q    <= 1'b0;
      end else begin
         we_q    <= 1'b0;
         fill_q  <= 1'b0;
         start_q <= 1'b0;
         busy_q  <= busy;

         if (!cs_s) begin
            if (low_cnt != LCW'(MIN_CS_LOW))
               low_cnt <= low_cnt + 1'b1;
         end else begin
            low_cnt <= '0;
         end

         if (start_q)
            armed <= 1'b1;
         else if (busy_q && !busy)
            armed <= 1'b0;

         if (!cs_s) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            rd_on     <= 1'b0;
            stat_mode <= 1'b0;
         end else if (cs_rise) begin
            if (armed && low_cnt >= LCW'(MIN_CS_LOW))
               stat_mode <= 1'b1;
         end else if (sk_rise && !stat_mode) begin
            case (st)
               ST_IDLE: begin
                  if (di_s && !busy) begin
                     st     <= ST_CMD;
                     cnt    <= '0;
                     cmd_sr <= '0;
                  end
               end
               ST_CMD: begin
                  cmd_sr <= nsr;
                  if (cnt == need - 5'd1) begin
                     cnt <= '0;
                     case (op)
                        OP_READ: begin
                           st    <= ST_READ;
                           ptr   <= addr;
                           rd_on <= 1'b1;
                           dreg  <= 1'b0;
                           bidx  <= '0;
                        end
                        OP_WRITE: begin
                           st      <= ST_DATA;
                           pend    <= PK_WORD;
                           waddr_q <= addr;
                           dsr     <= '0;
                        end
                        OP_ERASE: begin
                           st <= ST_HOLD;
                           if (prog_en) begin
                              we_q    <= 1'b1;
                              waddr_q <= addr;
                              wdata_q <= '1;
                              start_q <= 1'b1;
                           end
                        end
                        default: begin
                           case (sub)
                              SUB_UNLOCK: begin
                                 prog_en <= 1'b1;
                                 st      <= ST_HOLD;
                              end
                              SUB_LOCK: begin
                                 prog_en <= 1'b0;
                                 st      <= ST_HOLD;
                              end
                              SUB_CLEARALL: begin
                                 st <= ST_HOLD;
                                 if (prog_en) begin
                                    fill_q  <= 1'b1;
                                    wdata_q <= '1;
                                    start_q <= 1'b1;
                                 end
                              end
                              default: begin
                                 st   <= ST_DATA;
                                 pend <= PK_FILL;
                                 dsr  <= '0;
                              end
                           endcase
                        end
                     endcase
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_DATA: begin
                  dsr <= ndsr;
                  if (cnt[3:0] == wlast) begin
                     st <= ST_HOLD;
                     if (prog_en) begin
                        wdata_q <= ndsr;
                        start_q <= 1'b1;
                        if (pend == PK_WORD)
                           we_q <= 1'b1;
                        else
                           fill_q <= 1'b1;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_READ: begin
                  dreg <= rbit;
                  if (bidx == wlast) begin
                     bidx <= '0;
                     ptr  <= ptr_inc;
                  end else begin
                     bidx <= bidx + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign dout_oe = cs_s & (rd_on | stat_mode);
   assign dout    = stat_mode ? ~busy : dreg;
endmodule

// File: rtl/sereep_chk.sv
module sereep_chk #(
   parameter int SYNC_STAGES = 2,
   parameter int PROG_CYCLES = 2000
) (
   input logic clk,
   input logic rst,
   input logic cs,
   input logic dout,
   input logic dout_oe,
   input logic busy,
   input logic start_q,
   input logic prog_en,
   input logic stat_mode
);
   localparam int CW = $clog2(PROG_CYCLES + 1);
   logic [7:0]    cs_low_run;
   logic [CW-1:0] ref_left;

   always_ff @(posedge clk) begin
      if (rst) begin
         cs_low_run <= '0;
         ref_left   <= '0;
      end else begin
         if (cs)
            cs_low_run <= '0;
         else if (cs_low_run != 8'hFF)
            cs_low_run <= cs_low_run + 1'b1;
         if (start_q)
            ref_left <= CW'(PROG_CYCLES);
         else if (ref_left != '0)
            ref_left <= ref_left - 1'b1;
      end
   end

   // R12
   oe_off_when_deselected_chk: assert property (@(posedge clk) disable iff (rst)
      (!cs && cs_low_run >= 8'(SYNC_STAGES)) |-> !dout_oe);

   // R11
   busy_length_chk: assert property (@(posedge clk) disable iff (rst)
      busy == (ref_left != '0));

   // R11
   no_start_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
      start_q |-> !busy);

   // R8
   busy_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> prog_en);

   // R6
   read_leads_with_zero_chk: assert property (@(posedge clk) disable iff (rst)
      ($rose(dout_oe) && !stat_mode) |-> !dout);
endmodule

bind sereep_slave sereep_chk #(
   .SYNC_STAGES (SYNC_STAGES),
   .PROG_CYCLES (PROG_CYCLES)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .cs        (cs),
   .dout      (dout),
   .dout_oe   (dout_oe),
   .busy      (busy),
   .start_q   (start_q),
   .prog_en   (prog_en),
   .stat_mode (stat_mode)
);

// File: tb/sim_sereep_slave.sv
`timescale 1ns/1ps
module sim_sereep_slave;
   localparam int NB   = 32;
   localparam int PROG = 300;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cs = 1'b0, sk = 1'b0, di = 1'b0, org16 = 1'b0;
   logic dout, dout_oe;

   int total = 0;
   int bad   = 0;
   bit fin   = 0;
   logic [7:0] mdl [NB];

   always #10 clk = ~clk;

   sereep_slave #(
      .ARRAY_BYTES (NB),
      .PROG_CYCLES (PROG),
      .MIN_CS_LOW  (4),
      .SYNC_STAGES (2)
   ) u0 (
      .clk     (clk),
      .rst     (rst),
      .cs      (cs),
      .sk      (sk),
      .di      (di),
      .org16   (org16),
      .dout    (dout),
      .dout_oe (dout_oe)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input bit b);
      di = b;
      wclk(5);
      sk = 1'b1;
      wclk(5);
      sk = 1'b0;
   endtask

   task automatic send(input int v, input int n);
      for (int i = n - 1; i >= 0; i--) pulse(v[i]);
   endtask

   task automatic cmd(input bit o16, input int op, input int a, input int pre);
      org16 = o16;
      cs = 1'b1;
      wclk(4);
      for (int i = 0; i < pre; i++) pulse(1'b0);
      pulse(1'b1);
      send(op, 2);
      send(a, o16 ? 4 : 5);
   endtask

   task automatic end_cmd();
      di = 1'b0;
      cs = 1'b0;
      wclk(8);
   endtask

   task automatic rd_bits(input int w, output int v);
      v = 0;
      for (int i = 0; i < w; i++) begin
         wclk(5);
         v = (v << 1) | int'(dout);
         sk = 1'b1;
         wclk(5);
         sk = 1'b0;
      end
   endtask

   task automatic poll(input string req);
      int n;
      cs = 1'b1;
      wclk(6);
      chk(dout_oe && !dout, req, {dout_oe, dout}, 2);
      n = 0;
      while (dout !== 1'b1 && n < 2000) begin
         wclk(1);
         n++;
      end
      chk(dout_oe && dout, req, {dout_oe, dout}, 3);
      cs = 1'b0;
      wclk(8);
   endtask

   task automatic no_status(input string req);
      cs = 1'b1;
      wclk(6);
      chk(!dout_oe, req, dout_oe, 0);
      cs = 1'b0;
      wclk(8);
   endtask

   task automatic spec(input bit o16, input int sub, input bit has_data, input int d);
      cmd(o16, 0, sub << (o16 ? 2 : 3), 0);
      if (has_data) send(d, o16 ? 16 : 8);
      end_cmd();
   endtask

   task automatic read8(input int a, input int n, input int pre, input string req);
      int v;
      cmd(1'b0, 2, a, pre);
      rd_bits(1, v);
      chk(v == 0 && dout_oe, "R6 dummy bit", v, 0);
      for (int k = 0; k < n; k++) begin
         rd_bits(8, v);
         chk(v == int'(mdl[(a + k) % NB]), req, v, int'(mdl[(a + k) % NB]));
      end
      end_cmd();
   endtask

   task automatic read16(input int w, input int n, input string req);
      int v, e, ww;
      cmd(1'b1, 2, w, 0);
      rd_bits(1, v);
      chk(v == 0, "R6 dummy bit x16", v, 0);
      for (int k = 0; k < n; k++) begin
         ww = (w + k) % (NB / 2);
         e = {mdl[2*ww], mdl[2*ww+1]};
         rd_bits(16, v);
         chk(v == e, req, v, e);
      end
      end_cmd();
   endtask

   task automatic write8(input int a, input int d);
      cmd(1'b0, 1, a, 0);
      send(d, 8);
      end_cmd();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!fin) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int v;
      for (int i = 0; i < NB; i++) mdl[i] = 8'hFF;
      wclk(5);
      rst = 1'b0;
      wclk(5);
      // R1 R12: disabled output after reset
      chk(!dout_oe, "R1 R12 oe after reset", dout_oe, 0);
      // R1 R2: full sweep of erased array, with leading zero bits
      read8(0, NB, 2, "R1 R2 reset contents");

      // R8: write while disabled has no effect and no status
      write8(3, 8'h5A);
      no_status("R8 no busy when disabled");
      read8(3, 1, 0, "R8 disabled write ignored");

      // R4: enable, then sweep every byte
      spec(1'b0, 3, 1'b0, 0);
      for (int a = 0; a < NB; a++) begin
         write8(a, (a * 37 + 11) & 8'hFF);
         mdl[a] = 8'((a * 37 + 11) & 8'hFF);
         poll("R3 R10 write status");
      end
      // R7: wrap of 8-bit and 16-bit pointers
      read8(29, NB + 4, 0, "R7 x8 sequential wrap");
      read16(13, 20, "R5 R7 x16 sequential wrap");

      // R5: 16-bit write lands on bytes 2k and 2k+1
      cmd(1'b1, 1, 6, 0);
      send(16'hBEEF, 16);
      end_cmd();
      poll("R10 x16 write status");
      mdl[12] = 8'hBE;
      mdl[13] = 8'hEF;
      read8(12, 2, 0, "R5 byte mapping");

      // R9: erase one byte, overwrite without erase, erase a 16-bit word
      cmd(1'b0, 3, 7, 0);
      end_cmd();
      poll("R9 erase status");
      mdl[7] = 8'hFF;
      write8(8, 8'h0F);
      poll("R9 write status");
      write8(8, 8'hF0);
      poll("R9 overwrite status");
      mdl[8] = 8'hF0;
      read8(7, 2, 0, "R9 erase and overwrite");
      cmd(1'b1, 3, 2, 0);
      end_cmd();
      poll("R9 x16 erase status");
      mdl[4] = 8'hFF;
      mdl[5] = 8'hFF;
      read16(2, 1, "R9 x16 erase");

      // R11 R10: short CS low arms no status; command while busy ignored
      write8(20, 8'h33);
      cs = 1'b0;
      wclk(8);
      cs = 1'b1;
      wclk(6);
      chk(dout_oe && !dout, "R10 busy seen", {dout_oe, dout}, 2);
      cs = 1'b0;
      wclk(2);
      cs = 1'b1;
      wclk(2);
      chk(!dout_oe, "R10 short CS low gives no status", dout_oe, 0);
      send(0, 0);
      pulse(1'b1);
      send(1, 2);
      send(21, 5);
      send(8'h44, 8);
      end_cmd();
      poll("R11 still busy then ready");
      mdl[20] = 8'h33;
      read8(20, 2, 0, "R11 busy command ignored");

      // R10: CS rises only after the interval ended
      write8(22, 8'h77);
      cs = 1'b0;
      wclk(PROG + 40);
      no_status("R10 late CS rise no status");
      mdl[22] = 8'h77;

      // R12: partial command discarded on CS fall
      cs = 1'b1;
      wclk(4);
      pulse(1'b1);
      send(2, 2);
      send(1, 2);
      end_cmd();
      chk(!dout_oe, "R12 oe low with CS low", dout_oe, 0);
      read8(22, 1, 0, "R12 command after discard");

      // R4: write-all 16-bit, erase-all, write-all 8-bit
      spec(1'b1, 1, 1'b1, 16'h1234);
      poll("R4 write-all status");
      for (int i = 0; i < NB; i++) mdl[i] = (i % 2 == 0) ? 8'h12 : 8'h34;
      read8(0, NB, 0, "R4 write-all x16");
      spec(1'b0, 2, 1'b0, 0);
      poll("R4 erase-all status");
      for (int i = 0; i < NB; i++) mdl[i] = 8'hFF;
      read16(0, NB / 2, "R4 erase-all");
      spec(1'b0, 1, 1'b1, 8'hA5);
      poll("R4 write-all x8 status");
      for (int i = 0; i < NB; i++) mdl[i] = 8'hA5;

      // R8: disable, then every programming form is ignored
      spec(1'b0, 0, 1'b0, 0);
      spec(1'b0, 1, 1'b1, 8'h00);
      no_status("R8 write-all disabled");
      spec(1'b0, 2, 1'b0, 0);
      no_status("R8 erase-all disabled");
      cmd(1'b0, 3, 0, 0);
      end_cmd();
      write8(1, 8'h00);
      read8(0, NB, 0, "R8 array unchanged while disabled");

      rd_bits(0, v);
      fin = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule